// File: doc/BRIEF.md
# Multi-Context Translation Lookup with Permission Check

This block holds a small, fully associative table of address translation entries. It translates a 32-bit effective address into a 32-bit real address. Each lookup carries an access kind (fetch, load or store), the current instruction-side and data-side address-space bits, a privilege bit and three 8-bit context IDs that are all live at once. Every entry is compared against all three contexts in parallel. An entry with a zero context tag is global and matches any context.

Each entry has its own page size, from 4 KB to 256 MB in factors of four. Only the effective-address bits above that page's offset take part in the compare. On a hit, the entry's real page number replaces those bits and the offset passes through unchanged. The block also checks the access against the entry's six permission bits and returns the entry's five attribute bits.

Lookup results are registered. Outputs reflect the inputs sampled at the previous rising clock edge. Entries are loaded through a single-entry write port.

Top module: `tlb_ctx_lookup`

## Requirements
- R1: An entry takes part in a lookup only when its valid bit is 1 and its space bit equals the selected address-space bit. A fetch (access code 0) selects `is_i`. Load (1), store (2) and the reserved code (3) select `ds_i`.
- R2: A lookup hits an entry when the entry tag equals any one of `ctx0_i`, `ctx1_i` or `ctx2_i`.
- R3: An entry whose tag is 8'h00 matches whatever the three context inputs hold.
- R4: Size code k (1 to 9) gives a page of 4^k KB with an offset of 10+2k bits. Only effective-address bits from the offset width up to bit 31 are compared with the matching bits of the entry's 20-bit page number (EA bits 31:12).
- R5: An entry whose size code is 0 or 10 to 15 never matches.
- R6: On a hit, `ra_o` takes its bits above the page offset from the entry's page number field and its offset bits from the effective address.
- R7: Permission bits are bit0 user-read, bit1 user-write, bit2 user-execute, bit3 supervisor-read, bit4 supervisor-write and bit5 supervisor-execute. With `user_i`=1, fetch needs bit2, load needs bit0 and store needs bit1. With `user_i`=0, it needs bit5, bit3 and bit4 respectively. Access code 3 always faults. `perm_fault_o` is 1 on a hit that lacks the needed bit.
- R8: When several entries match, `multi_hit_o` is 1 and the outputs come from the lowest-index matching entry. A single match leaves `multi_hit_o` at 0.
- R9: On a miss, `hit_o`, `multi_hit_o`, `perm_fault_o`, `ra_o` and `attr_o` are all 0. On a hit, `attr_o` is the entry's attribute field.
- R10: Results appear one clock after the inputs are sampled. During and after reset, all outputs are 0 and all entries are invalid.
- R11: A write with `wr_en_i`=1 replaces entry `wr_idx_i` with the write fields, and lookups from the next cycle see it. Writing valid=0 removes the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | clog2(NUM_ENTRIES) | Entry index to write |
| wr_valid_i | input | 1 | Valid bit to write |
| wr_ts_i | input | 1 | Space bit to write |
| wr_tag_i | input | 8 | Context tag to write (0 = global) |
| wr_epn_i | input | 20 | Effective page number to write |
| wr_size_i | input | 4 | Page size code to write |
| wr_rpn_i | input | 20 | Real page number to write |
| wr_perm_i | input | 6 | Permission bits to write |
| wr_attr_i | input | 5 | Attribute bits to write |
| ea_i | input | 32 | Effective address |
| acc_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 reserved |
| is_i | input | 1 | Instruction-side address-space bit |
| ds_i | input | 1 | Data-side address-space bit |
| user_i | input | 1 | 1 = user, 0 = supervisor |
| ctx0_i | input | 8 | Context ID 0 |
| ctx1_i | input | 8 | Context ID 1 |
| ctx2_i | input | 8 | Context ID 2 |
| hit_o | output | 1 | Lookup hit |
| multi_hit_o | output | 1 | More than one entry matched |
| ra_o | output | 32 | Real address |
| perm_fault_o | output | 1 | Permission violation on a hit |
| attr_o | output | 5 | Page attributes |

## Verification
The bench builds the block with its defaults: 16 entries and three context inputs. The top index 15 is therefore reachable, and each of the three context slots is exercised as the matching one. The entry set spans the smallest (code 1), a middle (codes 2, 3) and the largest (code 9) page size, plus out-of-range codes 0 and 10. Two entries overlap so that the lowest-index priority is exercised.

// File: rtl/tlb_lookup_pkg.sv
package tlb_lookup_pkg;
  localparam int EA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int PN_W    = EA_W - OFF_W;
  localparam int CTX_W   = 8;
  localparam int PERM_W  = 6;
  localparam int ATTR_W  = 5;
  localparam int SIZE_W  = 4;
  localparam int MAX_SZ  = 9;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic              valid;
    logic              ts;
    logic [CTX_W-1:0]  tag;
    logic [PN_W-1:0]   epn;
    logic [SIZE_W-1:0] size;
    logic [PN_W-1:0]   rpn;
    logic [PERM_W-1:0] perm;
    logic [ATTR_W-1:0] attr;
  } tlb_entry_t;

  // page-number compare mask: code k clears the low 2k-2 bits of the page number
  function automatic logic [PN_W-1:0] pn_mask(logic [SIZE_W-1:0] code);
    logic [PN_W-1:0] m;
    m = '1;
    for (int k = 1; k <= MAX_SZ; k++)
      if (code == SIZE_W'(k)) m = {PN_W{1'b1}} << (2*k - 2);
    return m;
  endfunction
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_lookup_pkg::*;
#(
  parameter int NUM_CTX = 3
) (
  input  tlb_entry_t                       ent_i,
  input  logic [EA_W-1:0]                  ea_i,
  input  logic                             as_i,
  input  logic [NUM_CTX-1:0][CTX_W-1:0]    ctx_i,
  output logic                             match_o,
  output logic [PN_W-1:0]                  mask_o
);
  logic [NUM_CTX-1:0] ctx_eq;
  logic size_ok, tag_ok, pn_ok;

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    assign ctx_eq[c] = (ent_i.tag == ctx_i[c]);
  end

  assign mask_o  = pn_mask(ent_i.size);
  assign size_ok = (ent_i.size >= SIZE_W'(1)) && (ent_i.size <= SIZE_W'(MAX_SZ));
  assign tag_ok  = (ent_i.tag == '0) || (|ctx_eq);
  assign pn_ok   = (((ea_i[EA_W-1:OFF_W] ^ ent_i.epn) & mask_o) == '0);
  assign match_o = ent_i.valid && (ent_i.ts == as_i) && size_ok && tag_ok && pn_ok;
endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o,
  output logic             multi_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o = '0;
        gnt_o[i] = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  assign any_o   = |req_i;
  assign multi_o = |(req_i & (req_i - N'(1)));
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_lookup_pkg::*;
(
  input  logic [1:0]        acc_i,
  input  logic              user_i,
  input  logic [PERM_W-1:0] perm_i,
  output logic              fault_o
);
  logic ok;
  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_FETCH: ok = user_i ? perm_i[2] : perm_i[5];
      ACC_LOAD:  ok = user_i ? perm_i[0] : perm_i[3];
      ACC_STORE: ok = user_i ? perm_i[1] : perm_i[4];
      default:   ok = 1'b0;
    endcase
  end
  assign fault_o = !ok;
endmodule

// File: rtl/tlb_ctx_lookup.sv
module tlb_ctx_lookup
  import tlb_lookup_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [$clog2(NUM_ENTRIES)-1:0] wr_idx_i,
  input  logic                           wr_valid_i,
  input  logic                           wr_ts_i,
  input  logic [7:0]                     wr_tag_i,
  input  logic [19:0]                    wr_epn_i,
  input  logic [3:0]                     wr_size_i,
  input  logic [19:0]                    wr_rpn_i,
  input  logic [5:0]                     wr_perm_i,
  input  logic [4:0]                     wr_attr_i,
  input  logic [31:0]                    ea_i,
  input  logic [1:0]                     acc_i,
  input  logic                           is_i,
  input  logic                           ds_i,
  input  logic                           user_i,
  input  logic [7:0]                     ctx0_i,
  input  logic [7:0]                     ctx1_i,
  input  logic [7:0]                     ctx2_i,
  output logic                           hit_o,
  output logic                           multi_hit_o,
  output logic [31:0]                    ra_o,
  output logic                           perm_fault_o,
  output logic [4:0]                     attr_o
);
  localparam int IDX_W   = $clog2(NUM_ENTRIES);
  localparam int NUM_CTX = 3;

  tlb_entry_t tbl_q [NUM_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ENTRIES; i++) tbl_q[i] <= '0;
    end else if (wr_en_i) begin
      tbl_q[wr_idx_i] <= '{valid: wr_valid_i, ts: wr_ts_i, tag: wr_tag_i, epn: wr_epn_i,
                          size: wr_size_i, rpn: wr_rpn_i, perm: wr_perm_i, attr: wr_attr_i};
    end
  end

  logic [NUM_CTX-1:0][CTX_W-1:0] ctx;
  logic                          as_sel;
  logic [NUM_ENTRIES-1:0]        match;
  logic [PN_W-1:0]               mask [NUM_ENTRIES];

  assign ctx    = {ctx2_i, ctx1_i, ctx0_i};
  assign as_sel = (acc_e'(acc_i) == ACC_FETCH) ? is_i : ds_i;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    tlb_entry_match #(.NUM_CTX(NUM_CTX)) i_match (
      .ent_i  (tbl_q[e]),
      .ea_i   (ea_i),
      .as_i   (as_sel),
      .ctx_i  (ctx),
      .match_o(match[e]),
      .mask_o (mask[e])
    );
  end

  logic [NUM_ENTRIES-1:0] gnt;
  logic [IDX_W-1:0]       sel_idx;
  logic                   any_hit, multi;

  tlb_prio_sel #(.N(NUM_ENTRIES)) i_sel (
    .req_i  (match),
    .gnt_o  (gnt),
    .idx_o  (sel_idx),
    .any_o  (any_hit),
    .multi_o(multi)
  );

  tlb_entry_t      sel_ent;
  logic [PN_W-1:0] sel_mask;
  logic            fault;

  assign sel_ent  = tbl_q[sel_idx];
  assign sel_mask = mask[sel_idx];

  tlb_perm_check i_perm (
    .acc_i  (acc_i),
    .user_i (user_i),
    .perm_i (sel_ent.perm),
    .fault_o(fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o        <= 1'b0;
      multi_hit_o  <= 1'b0;
      ra_o         <= '0;
      perm_fault_o <= 1'b0;
      attr_o       <= '0;
    end else begin
      hit_o        <= any_hit;
      multi_hit_o  <= any_hit && multi;
      perm_fault_o <= any_hit && fault;
      attr_o       <= any_hit ? sel_ent.attr : '0;
      ra_o         <= any_hit ? {(sel_ent.rpn & sel_mask) | (ea_i[EA_W-1:OFF_W] & ~sel_mask),
                                 ea_i[OFF_W-1:0]} : '0;
    end
  end

  a_r9_miss_outputs_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (ra_o == '0 && attr_o == '0 && !perm_fault_o && !multi_hit_o));
  a_r6_offset_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ra_o[OFF_W-1:0] == $past(ea_i[OFF_W-1:0]));
  a_r8_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt) && ((gnt & ~match) == '0));
  a_r8_multi_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o |-> hit_o);
  a_r7_fault_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_fault_o |-> hit_o);
  a_r11_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> tbl_q[$past(wr_idx_i)].epn == $past(wr_epn_i));
endmodule

// File: tb/test_tlb_ctx_lookup.sv
module test_tlb_ctx_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_valid = 1'b0, wr_ts = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [7:0]  wr_tag = '0;
  logic [19:0] wr_epn = '0, wr_rpn = '0;
  logic [3:0]  wr_size = '0;
  logic [5:0]  wr_perm = '0;
  logic [4:0]  wr_attr = '0;
  logic [31:0] ea = '0;
  logic [1:0]  acc = '0;
  logic        is_b = 1'b0, ds_b = 1'b0, usr = 1'b0;
  logic [7:0]  c0 = '0, c1 = '0, c2 = '0;
  logic        hit, multi, fault;
  logic [31:0] ra;
  logic [4:0]  attr;

  int n_chk = 0, n_fail = 0;

  always #2.5ns clk = ~clk;

  tlb_ctx_lookup i_tlb_ctx_lookup (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_valid_i(wr_valid), .wr_ts_i(wr_ts),
    .wr_tag_i(wr_tag), .wr_epn_i(wr_epn), .wr_size_i(wr_size), .wr_rpn_i(wr_rpn),
    .wr_perm_i(wr_perm), .wr_attr_i(wr_attr),
    .ea_i(ea), .acc_i(acc), .is_i(is_b), .ds_i(ds_b), .user_i(usr),
    .ctx0_i(c0), .ctx1_i(c1), .ctx2_i(c2),
    .hit_o(hit), .multi_hit_o(multi), .ra_o(ra), .perm_fault_o(fault), .attr_o(attr)
  );

  typedef struct packed {
    logic [31:0] ea;
    logic [1:0]  acc;
    logic        is_b, ds_b, usr;
    logic [7:0]  c0, c1, c2;
    logic        hit, multi;
    logic [31:0] ra;
    logic        fault;
    logic [4:0]  attr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'hFFFF_F123, 2'd0, 1'b0, 1'b1, 1'b1, 8'h01, 8'h02, 8'h03, 1'b1, 1'b0, 32'h00AB_C123, 1'b0, 5'h11, 8'd3}, // R3 global
    '{32'h1000_ABCD, 2'd1, 1'b1, 1'b0, 1'b1, 8'h01, 8'h02, 8'h05, 1'b1, 1'b0, 32'h2345_ABCD, 1'b0, 5'h03, 8'd2}, // R2 slot 2
    '{32'h1000_ABCD, 2'd2, 1'b1, 1'b0, 1'b1, 8'h01, 8'h02, 8'h05, 1'b1, 1'b0, 32'h2345_ABCD, 1'b1, 5'h03, 8'd7}, // R7 user store
    '{32'h1000_ABCD, 2'd2, 1'b1, 1'b0, 1'b0, 8'h01, 8'h02, 8'h05, 1'b1, 1'b0, 32'h2345_ABCD, 1'b0, 5'h03, 8'd7}, // R7 sup store
    '{32'h1000_ABCD, 2'd1, 1'b0, 1'b1, 1'b1, 8'h01, 8'h02, 8'h05, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 5'h00, 8'd1}, // R1 ds mismatch
    '{32'h1000_0004, 2'd0, 1'b0, 1'b1, 1'b1, 8'h05, 8'h02, 8'h03, 1'b1, 1'b0, 32'h2345_0004, 1'b1, 5'h03, 8'd1}, // R1 fetch uses is
    '{32'h1000_ABCD, 2'd1, 1'b1, 1'b0, 1'b1, 8'h01, 8'h02, 8'h03, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 5'h00, 8'd2}, // R2 no ctx
    '{32'h4ABC_DEF0, 2'd0, 1'b1, 1'b0, 1'b1, 8'h01, 8'h22, 8'h03, 1'b1, 1'b0, 32'h8ABC_DEF0, 1'b0, 5'h1F, 8'd4}, // R4 256MB
    '{32'h4ABC_DEF0, 2'd1, 1'b0, 1'b1, 1'b0, 8'h01, 8'h22, 8'h03, 1'b1, 1'b0, 32'h8ABC_DEF0, 1'b1, 5'h1F, 8'd7}, // R7 sup load
    '{32'h2000_0000, 2'd1, 1'b0, 1'b0, 1'b0, 8'h77, 8'h01, 8'h02, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 5'h00, 8'd5}, // R5 code 0
    '{32'h3000_0456, 2'd1, 1'b0, 1'b0, 1'b1, 8'h33, 8'h01, 8'h02, 1'b1, 1'b1, 32'h0011_1456, 1'b0, 5'h04, 8'd8}, // R8 overlap
    '{32'h3000_2010, 2'd1, 1'b0, 1'b0, 1'b1, 8'h33, 8'h01, 8'h02, 1'b1, 1'b0, 32'h0022_2010, 1'b0, 5'h08, 8'd4}, // R4 16KB
    '{32'h6000_0FFF, 2'd1, 1'b0, 1'b1, 1'b1, 8'h01, 8'h02, 8'h09, 1'b1, 1'b0, 32'h0060_0FFF, 1'b0, 5'h02, 8'd2}, // R2 idx 15
    '{32'hFFFF_F000, 2'd3, 1'b1, 1'b0, 1'b0, 8'h01, 8'h02, 8'h03, 1'b1, 1'b0, 32'h00AB_C000, 1'b1, 5'h11, 8'd7}  // R7 rsvd
  };

  task automatic chk(input string what, input int req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic v, input logic ts, input logic [7:0] tag,
                    input logic [19:0] epn, input logic [3:0] sz, input logic [19:0] rpn,
                    input logic [5:0] perm, input logic [4:0] at);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_valid = v; wr_ts = ts; wr_tag = tag;
    wr_epn = epn; wr_size = sz; wr_rpn = rpn; wr_perm = perm; wr_attr = at;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input vec_t v);
    @(negedge clk);
    ea = v.ea; acc = v.acc; is_b = v.is_b; ds_b = v.ds_b; usr = v.usr;
    c0 = v.c0; c1 = v.c1; c2 = v.c2;
    @(negedge clk);
    chk("hit",   int'(v.req), 32'(hit),   32'(v.hit));
    chk("multi", int'(v.req), 32'(multi), 32'(v.multi));
    chk("ra",    int'(v.req), ra,         v.ra);
    chk("fault", int'(v.req), 32'(fault), 32'(v.fault));
    chk("attr",  int'(v.req), 32'(attr),  32'(v.attr));
  endtask

  initial begin
    #(200000 * 5ns);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("reset hit", 10, 32'(hit), 0);
    chk("reset ra", 10, ra, 0);
    chk("reset attr", 10, 32'(attr), 0);
    rst_n = 1'b1;
    // R10 empty table after reset: global-looking lookup misses
    look('{32'hFFFF_F123, 2'd0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 32'h0, 1'b0, 5'h0, 8'd10});

    wr(0,  1, 0, 8'h00, 20'hFFFFF, 4'd1, 20'h00ABC, 6'h3F, 5'h11);
    wr(1,  1, 0, 8'h05, 20'h10000, 4'd3, 20'h23450, 6'b011001, 5'h03);
    wr(2,  1, 1, 8'h22, 20'h40000, 4'd9, 20'h80000, 6'b100100, 5'h1F);
    wr(3,  1, 0, 8'h77, 20'h20000, 4'd0, 20'h12345, 6'h3F, 5'h01);
    wr(4,  1, 0, 8'h33, 20'h30000, 4'd1, 20'h00111, 6'h3F, 5'h04);
    wr(5,  1, 0, 8'h33, 20'h30000, 4'd2, 20'h00222, 6'h3F, 5'h08);
    wr(6,  1, 0, 8'h05, 20'h50000, 4'd1, 20'h00123, 6'h3F, 5'h10);
    wr(15, 1, 1, 8'h09, 20'h60000, 4'd1, 20'h00600, 6'h3F, 5'h02);

    for (int i = 0; i < NV; i++) look(VECS[i]);

    // R11 entry 6 visible, then removed by writing valid=0
    look('{32'h5000_0010, 2'd1, 1'b0, 1'b0, 1'b1, 8'h05, 8'h00, 8'h00, 1'b1, 1'b0, 32'h0012_3010, 1'b0, 5'h10, 8'd11});
    wr(6, 0, 0, 8'h05, 20'h50000, 4'd1, 20'h00123, 6'h3F, 5'h10);
    look('{32'h5000_0010, 2'd1, 1'b0, 1'b0, 1'b1, 8'h05, 8'h00, 8'h00, 1'b0, 1'b0, 32'h0, 1'b0, 5'h00, 8'd11});

    // R5 code 10 never matches; R8 single match then clears multi
    wr(5, 1, 0, 8'h33, 20'h30000, 4'd10, 20'h00222, 6'h3F, 5'h08);
    look('{32'h3000_2010, 2'd1, 1'b0, 1'b0, 1'b1, 8'h33, 8'h01, 8'h02, 1'b0, 1'b0, 32'h0, 1'b0, 5'h00, 8'd5});
    look('{32'h3000_0456, 2'd1, 1'b0, 1'b0, 1'b1, 8'h33, 8'h01, 8'h02, 1'b1, 1'b0, 32'h0011_1456, 1'b0, 5'h04, 8'd8});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule